// File: doc/BRIEF.md
# Domain divider group rate sequencer

This block moves a whole clock domain to one of a small set of named operating points. A caller pulses a start strobe with a requested domain rate in MHz. It also supplies the rate the parent PLL runs at now. The block looks the request up in a table fixed at build time. A matching point gives a target PLL rate and one 8-bit divide value for each divider of the domain. The block then programs the PLL and the divider bank in an order that keeps every divided clock at or below its final frequency during the change.

The PLL is reached through a request/acknowledge handshake toward a PLL controller. That controller returns a 2-bit result code with its acknowledge. The dividers are reached through a write port that carries a strobe, a register offset and the divide value. A parameter picks one of two domains:
- **Bus domain** (the default): four points and sixteen dividers.
- **Peripheral-clock domain**: six points and three dividers.

The sequencer has six states:
- **IDLE**: waits for start.
- **MATCH**: looks the captured request up in the table and chooses the order.
- **PLL_PRE**: requests the PLL before the dividers.
- **DIVS**: writes one divider per cycle.
- **PLL_POST**: requests the PLL after the dividers.
- **DONE**: a one-cycle completion pulse.

The transitions are:
- IDLE→MATCH on start.
- MATCH→DONE on a miss.
- MATCH→PLL_PRE when the target is below the current PLL rate.
- MATCH→DIVS otherwise.
- PLL_PRE→DIVS on acknowledge.
- DIVS→DONE after the last divider when the PLL went first.
- DIVS→PLL_POST after the last divider otherwise.
- PLL_POST→DONE on acknowledge.
- DONE→IDLE always.

Top module: `dom_rate_seq`

## Requirements
- R1: After reset, and whenever busy is low, the PLL request, divider write strobe and done are all low.
- R2: In the bus domain, requests of 200, 400, 600 and 800 MHz match points 0..3. While the PLL is requested, the target rate on the PLL rate output is 800, 800, 600 and 800 MHz respectively.
- R3: A requested rate that matches no point completes with status 3 (invalid) two cycles after the start edge. It makes no divider write and no PLL request.
- R4: When the target PLL rate is below the current PLL rate, the PLL request comes first. It is never concurrent with a divider write. The first divider write follows the cycle in which acknowledge is sampled.
- R5: When the target PLL rate is greater than or equal to the current rate, all divider writes come first. The PLL request follows the last write.
- R6: Dividers are written one per consecutive cycle in ascending offset order, with a step of 0x10. The bus domain makes 16 writes from 0x180 to 0x270. In the divider-first order the first write is two cycles after the start edge.
- R7: Bus-domain divide values for points 0..3 are 4/4/3/4 at offset 0x180, 4/2/1/1 at offset 0x190 and 24/24/18/24 at offset 0x260.
- R8: Done is a one-cycle pulse. Status carries the PLL result code captured with acknowledge: 0 ok, 1 timeout, 2 fault. Done comes one cycle after acknowledge in the PLL-last order, and one cycle after the last write in the PLL-first order.
- R9: A start strobe while busy is ignored, and the running sequence completes with its original point.
- R10: The peripheral-clock domain has six points at 25, 50, 75, 100, 125 and 150 MHz. Its PLL target is 600 MHz, except 700 MHz at 125 MHz. It writes three dividers at 0x380, 0x390 and 0x3A0. At 125 MHz the values are 6/5/10, and at 25 MHz they are 24/4/8.
- R11: The PLL request stays high until acknowledge is sampled, and the PLL rate output is stable while it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted in IDLE only |
| rate_mhz_i | input | RATE_W | Requested domain rate in MHz |
| cur_pll_mhz_i | input | RATE_W | Present PLL rate in MHz, captured with start |
| busy_o | output | 1 | High from start acceptance through DONE |
| pll_req_o | output | 1 | PLL reprogram request |
| pll_mhz_o | output | RATE_W | Target PLL rate for the request |
| pll_ack_i | input | 1 | PLL controller acknowledge |
| pll_code_i | input | 2 | PLL result code, valid with acknowledge |
| div_we_o | output | 1 | Divider write strobe |
| div_addr_o | output | ADDR_W | Divider register offset |
| div_val_o | output | VAL_W | Divide value |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result: 0 ok, 1 timeout, 2 fault, 3 invalid |

## Verification
Call the clock edge that samples start cycle 0. MATCH is due in cycle 1. In cycle 2 one of three things is due: a miss's done pulse, the first divider write, or the first PLL request. Each further divider is due exactly one cycle after the previous one, and done is due one cycle after the acknowledge or after the last write. The bench samples every output at the falling edge. It numbers those samples from the start edge and records the cycle of each write, request, acknowledge and done. It then compares those cycle numbers with the offsets above instead of waiting on events.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_PLL_PRE,
        ST_DIVS,
        ST_PLL_POST,
        ST_DONE
    } dsq_state_e;

    localparam logic [1:0] DSQ_OK      = 2'd0;
    localparam logic [1:0] DSQ_TIMEOUT = 2'd1;
    localparam logic [1:0] DSQ_FAULT   = 2'd2;
    localparam logic [1:0] DSQ_INVALID = 2'd3;

    localparam int DSQ_ADDR_STEP = 'h10;

    // domain 0: bus domain, domain 1: peripheral-clock domain
    function automatic int dsq_num_points(int dom);
        return (dom == 0) ? 4 : 6;
    endfunction

    function automatic int dsq_num_divs(int dom);
        return (dom == 0) ? 16 : 3;
    endfunction

    function automatic int dsq_base_addr(int dom);
        return (dom == 0) ? 'h180 : 'h380;
    endfunction

    function automatic int dsq_point_rate(int dom, int pt);
        return (dom == 0) ? 200 * (pt + 1) : 25 * (pt + 1);
    endfunction

    function automatic int dsq_point_pll(int dom, int pt);
        if (dom == 0)
            return (pt == 2) ? 600 : 800;
        return (pt == 4) ? 700 : 600;
    endfunction

endpackage

// File: rtl/dsq_point_match.sv
module dsq_point_match
    import dsq_pkg::*;
#(
    parameter int DOMAIN = 0,
    parameter int RATE_W = 11,
    parameter int PT_W   = 2
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic              hit_o,
    output logic [PT_W-1:0]   pt_o,
    output logic [RATE_W-1:0] pll_o
);

    localparam int NPTS = dsq_num_points(DOMAIN);

    always_comb begin
        hit_o = 1'b0;
        pt_o  = '0;
        pll_o = '0;
        for (int i = 0; i < NPTS; i++) begin
            if (rate_i == RATE_W'(dsq_point_rate(DOMAIN, i))) begin
                hit_o = 1'b1;
                pt_o  = PT_W'(i);
                pll_o = RATE_W'(dsq_point_pll(DOMAIN, i));
            end
        end
    end

endmodule

// File: rtl/dsq_div_table.sv
module dsq_div_table #(
    parameter int DOMAIN = 0,
    parameter int PT_W   = 2,
    parameter int DIV_W  = 4,
    parameter int VAL_W  = 8
) (
    input  logic [PT_W-1:0]  pt_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [VAL_W-1:0] val_o
);

    // one row per divider, byte k holds the value for point k
    logic [63:0] row;

    generate
        if (DOMAIN == 0) begin : g_bus
            always_comb begin
                unique case (int'(div_i))
                    0, 8, 10, 13: row = {32'd0, 8'd4,  8'd3,  8'd4,  8'd4};
                    1:            row = {32'd0, 8'd1,  8'd1,  8'd2,  8'd4};
                    6:            row = {32'd0, 8'd1,  8'd1,  8'd1,  8'd1};
                    11:           row = {32'd0, 8'd8,  8'd6,  8'd8,  8'd8};
                    12, 14:       row = {32'd0, 8'd24, 8'd18, 8'd24, 8'd24};
                    15:           row = {32'd0, 8'd16, 8'd12, 8'd16, 8'd16};
                    default:      row = {32'd0, 8'd2,  8'd2,  8'd2,  8'd2};
                endcase
            end
        end else begin : g_periph
            always_comb begin
                unique case (int'(div_i))
                    0:       row = {16'd0, 8'd4, 8'd6,  8'd6, 8'd8, 8'd12, 8'd24};
                    1:       row = {16'd0, 8'd4, 8'd5,  8'd4, 8'd4, 8'd4,  8'd4};
                    default: row = {16'd0, 8'd8, 8'd10, 8'd8, 8'd8, 8'd8,  8'd8};
                endcase
            end
        end
    endgenerate

    assign val_o = VAL_W'(row[8*pt_i +: 8]);

endmodule

// File: rtl/dom_rate_seq.sv
module dom_rate_seq
    import dsq_pkg::*;
#(
    parameter int DOMAIN = 0,
    parameter int RATE_W = 11,
    parameter int ADDR_W = 12,
    parameter int VAL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_mhz_i,
    input  logic [RATE_W-1:0] cur_pll_mhz_i,
    output logic              busy_o,
    output logic              pll_req_o,
    output logic [RATE_W-1:0] pll_mhz_o,
    input  logic              pll_ack_i,
    input  logic [1:0]        pll_code_i,
    output logic              div_we_o,
    output logic [ADDR_W-1:0] div_addr_o,
    output logic [VAL_W-1:0]  div_val_o,
    output logic              done_o,
    output logic [1:0]        status_o
);

    localparam int NPTS  = dsq_num_points(DOMAIN);
    localparam int NDIVS = dsq_num_divs(DOMAIN);
    localparam int PT_W  = (NPTS > 1) ? $clog2(NPTS) : 1;
    localparam int DIV_W = (NDIVS > 1) ? $clog2(NDIVS) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(dsq_base_addr(DOMAIN));
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(DSQ_ADDR_STEP);
    localparam logic [DIV_W-1:0]  LAST_D = DIV_W'(NDIVS - 1);

    dsq_state_e        state_q, state_d;
    logic [RATE_W-1:0] rate_q, cur_q, tgt_q;
    logic [PT_W-1:0]   pt_q;
    logic [DIV_W-1:0]  idx_q;
    logic              pre_q;
    logic [1:0]        stat_q;

    logic              m_hit;
    logic [PT_W-1:0]   m_pt;
    logic [RATE_W-1:0] m_pll;
    logic [VAL_W-1:0]  tbl_val;
    logic              last_div;

    dsq_point_match #(
        .DOMAIN (DOMAIN),
        .RATE_W (RATE_W),
        .PT_W   (PT_W)
    ) u_match (
        .rate_i (rate_q),
        .hit_o  (m_hit),
        .pt_o   (m_pt),
        .pll_o  (m_pll)
    );

    dsq_div_table #(
        .DOMAIN (DOMAIN),
        .PT_W   (PT_W),
        .DIV_W  (DIV_W),
        .VAL_W  (VAL_W)
    ) u_table (
        .pt_i   (pt_q),
        .div_i  (idx_q),
        .val_o  (tbl_val)
    );

    assign last_div = (idx_q == LAST_D);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_MATCH;
            ST_MATCH: begin
                if (!m_hit)            state_d = ST_DONE;
                else if (m_pll < cur_q) state_d = ST_PLL_PRE;
                else                   state_d = ST_DIVS;
            end
            ST_PLL_PRE:  if (pll_ack_i) state_d = ST_DIVS;
            ST_DIVS:     if (last_div) state_d = pre_q ? ST_DONE : ST_PLL_POST;
            ST_PLL_POST: if (pll_ack_i) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            cur_q  <= '0;
            tgt_q  <= '0;
            pt_q   <= '0;
            idx_q  <= '0;
            pre_q  <= 1'b0;
            stat_q <= DSQ_OK;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    rate_q <= rate_mhz_i;
                    cur_q  <= cur_pll_mhz_i;
                end
                ST_MATCH: begin
                    pt_q   <= m_pt;
                    tgt_q  <= m_pll;
                    idx_q  <= '0;
                    pre_q  <= m_hit && (m_pll < cur_q);
                    stat_q <= m_hit ? DSQ_OK : DSQ_INVALID;
                end
                ST_PLL_PRE, ST_PLL_POST: if (pll_ack_i) stat_q <= pll_code_i;
                ST_DIVS:  idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        pll_req_o  = (state_q == ST_PLL_PRE) || (state_q == ST_PLL_POST);
        div_we_o   = (state_q == ST_DIVS);
        done_o     = (state_q == ST_DONE);
        pll_mhz_o  = tgt_q;
        div_addr_o = BASE_A + ADDR_W'(idx_q) * STEP_A;
        div_val_o  = tbl_val;
        status_o   = stat_q;
    end

endmodule

// File: rtl/dom_rate_seq_chk.sv
module dom_rate_seq_chk #(
    parameter int RATE_W = 11,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              pll_req_o,
    input logic [RATE_W-1:0] pll_mhz_o,
    input logic              pll_ack_i,
    input logic              div_we_o,
    input logic [ADDR_W-1:0] div_addr_o,
    input logic              done_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pll_req_o && !div_we_o && !done_o)); // R1

    AST_PLL_DIV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_req_o && div_we_o)); // R4

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        div_we_o |=> (!div_we_o ||
            div_addr_o == $past(div_addr_o) + ADDR_W'(dsq_pkg::DSQ_ADDR_STEP))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req_o && !pll_ack_i) |=> pll_req_o); // R11

    AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req_o |=> (!pll_req_o || $stable(pll_mhz_o))); // R11

endmodule

bind dom_rate_seq dom_rate_seq_chk #(
    .RATE_W (RATE_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .pll_req_o  (pll_req_o),
    .pll_mhz_o  (pll_mhz_o),
    .pll_ack_i  (pll_ack_i),
    .div_we_o   (div_we_o),
    .div_addr_o (div_addr_o),
    .done_o     (done_o)
);

// File: tb/dom_rate_seq_tb_top.sv
module dom_rate_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        sel = 1'b0;
    logic        start = 1'b0;
    logic [10:0] rate_in = '0, cur_in = '0;
    logic        ack = 1'b0;
    logic [1:0]  code = '0;

    logic        b_busy, b_req, b_we, b_done, t_busy, t_req, t_we, t_done;
    logic [10:0] b_mhz, t_mhz;
    logic [11:0] b_addr, t_addr;
    logic [7:0]  b_val, t_val;
    logic [1:0]  b_stat, t_stat;

    dom_rate_seq #(.DOMAIN(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start && !sel), .rate_mhz_i(rate_in),
        .cur_pll_mhz_i(cur_in), .busy_o(b_busy), .pll_req_o(b_req), .pll_mhz_o(b_mhz),
        .pll_ack_i(ack && !sel), .pll_code_i(code), .div_we_o(b_we), .div_addr_o(b_addr),
        .div_val_o(b_val), .done_o(b_done), .status_o(b_stat));

    dom_rate_seq #(.DOMAIN(1)) dut_t (
        .clk(clk), .rst_n(rst_n), .start_i(start && sel), .rate_mhz_i(rate_in),
        .cur_pll_mhz_i(cur_in), .busy_o(t_busy), .pll_req_o(t_req), .pll_mhz_o(t_mhz),
        .pll_ack_i(ack && sel), .pll_code_i(code), .div_we_o(t_we), .div_addr_o(t_addr),
        .div_val_o(t_val), .done_o(t_done), .status_o(t_stat));

    wire        o_busy = sel ? t_busy : b_busy;
    wire        o_req  = sel ? t_req  : b_req;
    wire        o_we   = sel ? t_we   : b_we;
    wire        o_done = sel ? t_done : b_done;
    wire [10:0] o_mhz  = sel ? t_mhz  : b_mhz;
    wire [11:0] o_addr = sel ? t_addr : b_addr;
    wire [7:0]  o_val  = sel ? t_val  : b_val;
    wire [1:0]  o_stat = sel ? t_stat : b_stat;

    int total = 0, bad = 0;
    int wr_n, wr_before_req, first_wr, last_wr, ack_cyc, done_cyc, done_cnt, req_cnt, got_stat, req_mhz;
    bit addr_ok, req_seen;
    int log_addr [32];
    int log_val  [32];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int val_at(input int addr);
        for (int i = 0; i < wr_n && i < 32; i++)
            if (log_addr[i] == addr) return log_val[i];
        return -1;
    endfunction

    // cycle c counts falling edges after the edge that samples start
    task automatic run_op(input int rate, input int cur, input int dly,
                          input logic [1:0] rc, input bit poke);
        wr_n = 0; wr_before_req = -1; first_wr = -1; last_wr = -1; ack_cyc = -1;
        done_cyc = -1; done_cnt = 0; req_cnt = 0; got_stat = -1; req_mhz = -1;
        addr_ok = 1'b1; req_seen = 1'b0;
        @(negedge clk);
        start = 1'b1; rate_in = 11'(rate); cur_in = 11'(cur); code = rc;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c < 400; c++) begin
            if (o_req) begin
                if (!req_seen) begin
                    req_seen = 1'b1; wr_before_req = wr_n; req_mhz = int'(o_mhz);
                end
                req_cnt++;
            end
            if (o_we) begin
                if (wr_n < 32) begin
                    log_addr[wr_n] = int'(o_addr); log_val[wr_n] = int'(o_val);
                    if (wr_n > 0 && log_addr[wr_n] <= log_addr[wr_n-1]) addr_ok = 1'b0;
                end
                if (first_wr < 0) first_wr = c;
                last_wr = c;
                wr_n++;
            end
            if (o_done) begin
                done_cnt++;
                if (done_cyc < 0) begin done_cyc = c; got_stat = int'(o_stat); end
            end
            ack = o_req && (req_cnt == dly + 1);
            if (ack) ack_cyc = c;
            start = poke && (c == 3);
            if (poke && c == 3) rate_in = 11'd600;
            if (done_cyc >= 0 && c >= done_cyc + 3) break;
            @(negedge clk);
        end
        ack = 1'b0; start = 1'b0;
        chk(done_cyc >= 0, "R8 operation completes", done_cyc, 1);
        chk(done_cnt == 1, "R8 done single pulse", done_cnt, 1);
        chk(!o_busy, "R1 idle after done", int'(o_busy), 0);
    endtask

    task automatic t_reset;
        chk(!b_busy && !b_req && !b_we && !b_done, "R1 bus reset quiet",
            int'({b_busy, b_req, b_we, b_done}), 0);
        chk(!t_busy && !t_req && !t_we && !t_done, "R1 periph reset quiet",
            int'({t_busy, t_req, t_we, t_done}), 0);
    endtask

    task automatic t_up_400;
        run_op(400, 600, 2, 2'd0, 1'b0);
        chk(req_mhz == 800, "R2 target for 400", req_mhz, 800);
        chk(wr_before_req == 16, "R5 dividers before PLL", wr_before_req, 16);
        chk(wr_n == 16, "R6 sixteen writes", wr_n, 16);
        chk(first_wr == 2, "R6 first write cycle", first_wr, 2);
        chk(last_wr - first_wr + 1 == 16, "R6 consecutive writes", last_wr - first_wr + 1, 16);
        chk(addr_ok && log_addr[0] == 'h180 && log_addr[15] == 'h270, "R6 offsets ascending",
            log_addr[15], 'h270);
        chk(val_at('h190) == 2, "R7 0x190 at 400", val_at('h190), 2);
        chk(val_at('h260) == 24, "R7 0x260 at 400", val_at('h260), 24);
        chk(done_cyc == ack_cyc + 1, "R8 done after ack", done_cyc, ack_cyc + 1);
        chk(got_stat == 0, "R8 status ok", got_stat, 0);
    endtask

    task automatic t_equal_800;
        run_op(800, 800, 0, 2'd0, 1'b0);
        chk(req_mhz == 800, "R2 target for 800", req_mhz, 800);
        chk(wr_before_req == 16, "R5 equal rate writes first", wr_before_req, 16);
        chk(val_at('h190) == 1, "R7 0x190 at 800", val_at('h190), 1);
    endtask

    task automatic t_down_600;
        run_op(600, 800, 1, 2'd1, 1'b0);
        chk(req_mhz == 600, "R2 target for 600", req_mhz, 600);
        chk(wr_before_req == 0, "R4 PLL before dividers", wr_before_req, 0);
        chk(first_wr == ack_cyc + 1, "R4 first write after ack", first_wr, ack_cyc + 1);
        chk(wr_n == 16, "R6 sixteen writes", wr_n, 16);
        chk(val_at('h180) == 3, "R7 0x180 at 600", val_at('h180), 3);
        chk(val_at('h260) == 18, "R7 0x260 at 600", val_at('h260), 18);
        chk(done_cyc == last_wr + 1, "R8 done after last write", done_cyc, last_wr + 1);
        chk(got_stat == 1, "R8 timeout code", got_stat, 1);
    endtask

    task automatic t_invalid;
        run_op(300, 800, 0, 2'd0, 1'b0);
        chk(got_stat == 3, "R3 invalid status", got_stat, 3);
        chk(done_cyc == 2, "R3 done cycle", done_cyc, 2);
        chk(wr_n == 0, "R3 no writes", wr_n, 0);
        chk(!req_seen, "R3 no PLL request", int'(req_seen), 0);
    endtask

    task automatic t_busy_start;
        run_op(200, 200, 3, 2'd2, 1'b1);
        chk(req_mhz == 800, "R9 target kept", req_mhz, 800);
        chk(wr_n == 16, "R9 one write set", wr_n, 16);
        chk(val_at('h190) == 4, "R9 0x190 keeps point 200", val_at('h190), 4);
        chk(val_at('h180) == 4, "R7 0x180 at 200", val_at('h180), 4);
        chk(got_stat == 2, "R8 fault code", got_stat, 2);
    endtask

    task automatic t_periph;
        sel = 1'b1;
        run_op(125, 600, 0, 2'd0, 1'b0);
        chk(req_mhz == 700, "R10 target at 125", req_mhz, 700);
        chk(wr_n == 3 && wr_before_req == 3, "R10 three writes first", wr_n, 3);
        chk(val_at('h380) == 6, "R10 0x380 at 125", val_at('h380), 6);
        chk(val_at('h390) == 5, "R10 0x390 at 125", val_at('h390), 5);
        chk(val_at('h3A0) == 10, "R10 0x3A0 at 125", val_at('h3A0), 10);
        run_op(25, 700, 0, 2'd0, 1'b0);
        chk(req_mhz == 600 && wr_before_req == 0, "R10 lower target first", req_mhz, 600);
        chk(val_at('h380) == 24 && val_at('h390) == 4 && val_at('h3A0) == 8,
            "R10 values at 25", val_at('h380), 24);
        sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_up_400();
        t_equal_800();
        t_down_600();
        t_invalid();
        t_busy_start();
        t_periph();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule